// File: doc/BRIEF.md
# Flash Page-Range Read Burst Splitter

This block sits on the host side of a flash save-memory link and turns one request, "read pages S through E", into a sequence of burst descriptors for a separate transfer engine. Each descriptor gives a bus address and a byte length. A burst never spans a multiple of 256 pages, so a long range is cut at every such multiple. Pages are 128 bytes, and every burst moves whole pages.

Flash parts come in two addressing flavours. On the newer kind a page sits at the window base plus the page number times 128. On the older kind the address step per page is halved to 64. The requester chooses the flavour for each request. After reset, and whenever the surrounding logic reports that the device has been switched into array-read mode, the first burst is preceded by one dummy 32-bit read of the window base. A malformed range raises an error pulse and yields no descriptors. A done pulse marks acceptance of the last descriptor.

Top module: `page_read_splitter`

## Requirements
- R1: After reset `desc_valid`, `busy`, `done` and `err` are all low.
- R2: The first descriptor after reset, or after a `rd_mode_enter` pulse, is a dummy access with `desc_dummy`=1, address equal to the window base and length 4. Later requests are not preceded by a dummy until `rd_mode_enter` pulses again.
- R3: No burst crosses a page number that is a multiple of 256. For example, pages 254 to 520 produce bursts of 254–255, 256–511 and 512–520, in ascending order.
- R4: With `legacy`=0 the burst address is the base (default 0x0800_0000) plus the first page times 128.
- R5: With `legacy`=1 the burst address is the base plus the first page times 64.
- R6: The burst length in bytes equals the burst's page count times 128.
- R7: While `desc_valid` is high and `desc_ready` is low, address, length and dummy flag stay unchanged, and `desc_valid` stays high.
- R8: A request whose end page is below its start page, or whose end page exceeds 0x3FF, makes `err` high for exactly the cycle after the start strobe. It produces no descriptor.
- R9: `done` is high for exactly the cycle after the final burst descriptor is accepted, and is low at all other times.
- R10: A start strobe that arrives while `busy` is high is ignored. The descriptors of the running request are unchanged and no extra descriptors follow.
- R11: A range that starts on a 256-page multiple and covers 256 pages produces a single burst of length 32768 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| start_page | input | 16 | First page of the range |
| end_page | input | 16 | Last page of the range (inclusive) |
| legacy | input | 1 | 1 selects the older 64-byte address step per page |
| rd_mode_enter | input | 1 | Pulse: device just entered array-read mode, re-arms the dummy access |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_addr | output | 32 | Bus address of the access |
| desc_len | output | 16 | Byte length of the access |
| desc_dummy | output | 1 | Descriptor is the dummy 32-bit read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the last burst is accepted |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
A wrong current-page register shows up in the next descriptor's address and length as soon as the preceding one is accepted, so every descriptor in a sequence is compared with a value the bench computes itself. A dummy-arm flag that is cleared or set wrongly shows at the very first descriptor of a request, through either an extra or a missing base-address access of length 4. A faulty end-of-range decision shows within one cycle of the last acceptance, through a missing `done` or a stray extra burst. Stalled consumers and strobes during a running request show up on the held descriptor fields.

// File: rtl/page_read_splitter.sv
module page_read_splitter #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0800_0000,
  parameter int PAGE_W = 10,
  parameter int REQ_W = 16,
  parameter int SEG_LOG = 8,
  parameter int PAGE_LOG = 7,
  parameter int DUMMY_BYTES = 4,
  localparam int LEN_W = SEG_LOG + PAGE_LOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  start_page,
  input  logic [REQ_W-1:0]  end_page,
  input  logic              legacy,
  input  logic              rd_mode_enter,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [LEN_W-1:0]  desc_len,
  output logic              desc_dummy,
  output logic              busy,
  output logic              done,
  output logic              err
);

  typedef enum logic [1:0] {S_IDLE, S_DUMMY, S_BURST} state_t;

  state_t             st_q;
  logic [PAGE_W-1:0]  cur_q, last_q;
  logic               leg_q, arm_q, done_q, err_q;

  logic               bad, accept, last_seg;
  logic [PAGE_W-1:0]  seg_end, stop;
  logic [SEG_LOG:0]   cnt;
  logic [ADDR_W-1:0]  page_off;

  assign bad      = (end_page < start_page) || (end_page[REQ_W-1:PAGE_W] != '0);
  assign accept   = desc_valid && desc_ready;
  assign seg_end  = cur_q | PAGE_W'((1 << SEG_LOG) - 1);
  assign last_seg = seg_end >= last_q;
  assign stop     = last_seg ? last_q : seg_end;
  assign cnt      = (SEG_LOG+1)'(stop - cur_q) + (SEG_LOG+1)'(1);
  assign page_off = leg_q ? (ADDR_W'(cur_q) << (PAGE_LOG - 1))
                          : (ADDR_W'(cur_q) << PAGE_LOG);

  assign desc_valid = st_q != S_IDLE;
  assign busy       = st_q != S_IDLE;
  assign desc_dummy = st_q == S_DUMMY;
  assign desc_addr  = desc_dummy ? BASE_ADDR : BASE_ADDR + page_off;
  assign desc_len   = desc_dummy ? LEN_W'(DUMMY_BYTES) : LEN_W'(cnt) << PAGE_LOG;
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      last_q <= '0;
      leg_q  <= 1'b0;
      arm_q  <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == S_DUMMY && accept) arm_q <= 1'b0;
      if (rd_mode_enter) arm_q <= 1'b1;
      case (st_q)
        S_IDLE:
          if (start) begin
            if (bad) begin
              err_q <= 1'b1;
            end else begin
              cur_q  <= start_page[PAGE_W-1:0];
              last_q <= end_page[PAGE_W-1:0];
              leg_q  <= legacy;
              st_q   <= arm_q ? S_DUMMY : S_BURST;
            end
          end
        S_DUMMY:
          if (accept) st_q <= S_BURST;
        S_BURST:
          if (accept) begin
            if (last_seg) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              cur_q <= seg_end + PAGE_W'(1);
            end
          end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

module page_read_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0800_0000,
  parameter int SEG_LOG = 8,
  parameter int PAGE_LOG = 7,
  parameter int DUMMY_BYTES = 4,
  parameter int LEN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [LEN_W-1:0]  desc_len,
  input logic              desc_dummy,
  input logic              done,
  input logic              err,
  input logic              leg
);

  logic [ADDR_W-1:0] off, pg;
  logic [LEN_W:0]    span;

  always_comb begin
    off  = desc_addr - BASE_ADDR;
    pg   = leg ? (off >> (PAGE_LOG - 1)) : (off >> PAGE_LOG);
    span = (LEN_W+1)'(pg[SEG_LOG-1:0]) + (LEN_W+1)'(desc_len >> PAGE_LOG);
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr)
                                  && $stable(desc_len) && $stable(desc_dummy));

  assert_dummy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_dummy |-> desc_addr == BASE_ADDR
                                 && desc_len == LEN_W'(DUMMY_BYTES));

  assert_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_dummy |-> desc_len[PAGE_LOG-1:0] == '0 && desc_len != '0);

  assert_nocross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_dummy |-> span <= (LEN_W+1)'(1 << SEG_LOG));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(desc_valid && desc_ready && !desc_dummy));

  assert_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !desc_valid && !done);

endmodule

bind page_read_splitter page_read_splitter_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SEG_LOG(SEG_LOG),
  .PAGE_LOG(PAGE_LOG), .DUMMY_BYTES(DUMMY_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_addr(desc_addr), .desc_len(desc_len), .desc_dummy(desc_dummy),
  .done(done), .err(err), .leg(leg_q)
);

// File: tb/page_read_splitter_tb.sv
module page_read_splitter_tb;

  localparam logic [31:0] BASE = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_page = '0;
  logic [15:0] end_page = '0;
  logic        legacy = 1'b0;
  logic        rd_mode_enter = 1'b0;
  logic        desc_ready = 1'b0;
  logic        desc_valid, desc_dummy, busy, done, err;
  logic [31:0] desc_addr;
  logic [15:0] desc_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  page_read_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .end_page(end_page), .legacy(legacy), .rd_mode_enter(rd_mode_enter),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_len(desc_len), .desc_dummy(desc_dummy), .busy(busy),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int s, input int e, input bit leg);
    @(negedge clk);
    start_page = 16'(s); end_page = 16'(e); legacy = leg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int s, input int e, input bit leg, input bit exp_dummy, input bit stall);
    int p = s;
    if (exp_dummy) begin
      check(desc_valid && desc_dummy, "R2 dummy present", {desc_valid, desc_dummy}, 3);
      check(desc_addr == BASE, "R2 dummy addr", desc_addr, BASE);
      check(desc_len == 16'd4, "R2 dummy len", desc_len, 4);
      if (stall) begin
        repeat (2) @(negedge clk);
        check(desc_valid && desc_dummy && desc_addr == BASE && desc_len == 16'd4,
              "R7 dummy held", desc_addr, BASE);
      end
      desc_ready = 1'b1; @(negedge clk); desc_ready = 1'b0;
    end
    while (p <= e) begin
      int seg_end = (p / 256) * 256 + 255;
      int stop = (seg_end < e) ? seg_end : e;
      longint ea = longint'(BASE) + longint'(p) * (leg ? 64 : 128);
      longint el = longint'(stop - p + 1) * 128;
      check(desc_valid && !desc_dummy, "R3 burst present", {desc_valid, desc_dummy}, 2);
      check(desc_addr == 32'(ea), leg ? "R5 burst addr" : "R4 burst addr", desc_addr, ea);
      check(desc_len == 16'(el), "R6 burst len", desc_len, el);
      if (stall) begin
        desc_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(desc_valid && desc_addr == 32'(ea) && desc_len == 16'(el),
              "R7 burst held", desc_addr, ea);
      end
      desc_ready = 1'b1; @(negedge clk); desc_ready = 1'b0;
      check(done == (stop == e), "R9 done timing", done, stop == e);
      p = stop + 1;
    end
    check(!desc_valid, "R3 no extra burst", desc_valid, 0);
    @(negedge clk);
    check(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    check(!desc_valid && !busy && !done && !err, "R1 reset state",
          {desc_valid, busy, done, err}, 0);
  endtask

  task automatic t_split_with_dummy;
    issue(254, 520, 1'b0);
    collect(254, 520, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_no_second_dummy;
    issue(10, 12, 1'b0);
    check(!desc_dummy, "R2 no repeat dummy", desc_dummy, 0);
    collect(10, 12, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_legacy;
    issue(300, 700, 1'b1);
    collect(300, 700, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_full_segment;
    issue(256, 511, 1'b0);
    check(desc_len == 16'd32768, "R11 full burst len", desc_len, 32768);
    collect(256, 511, 1'b0, 1'b0, 1'b0);
    issue(0, 1023, 1'b0);
    collect(0, 1023, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mode_reentry;
    @(negedge clk); rd_mode_enter = 1'b1;
    @(negedge clk); rd_mode_enter = 1'b0;
    issue(5, 5, 1'b1);
    collect(5, 5, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_err(input int s, input int e);
    @(negedge clk);
    start_page = 16'(s); end_page = 16'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err && !desc_valid, "R8 err pulse", {err, desc_valid}, 2);
    @(negedge clk);
    check(!err, "R8 err one cycle", err, 0);
    for (int i = 0; i < 4; i++) begin
      check(!desc_valid && !busy, "R8 no descriptor", desc_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_ignore;
    issue(0, 300, 1'b0);
    issue(900, 901, 1'b1);
    collect(0, 300, 1'b0, 1'b0, 1'b0);
    repeat (3) begin
      check(!desc_valid, "R10 strobe ignored", desc_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_with_dummy();
    t_no_second_dummy();
    t_legacy();
    t_full_segment();
    t_mode_reentry();
    t_err(20, 10);
    t_err(1000, 1024);
    t_busy_ignore();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule